// File: doc/BRIEF.md
# Condition-Code Branch Evaluation Unit

This block keeps a five-bit condition register and resolves short-form conditional branches against it. A compare strobe loads the register from the ordering of two data operands. The unsigned ordering is tracked apart from the signed ordering, so one compare can feed both kinds of branch. When a branch is presented, the unit decodes its condition code and its displacement. In the same cycle it returns the next program counter, a taken indication and an illegal-opcode indication.

The program counter it receives has already been stepped past the 2-byte branch, and the displacement is added to that value. The flag register is updated at the clock edge. Branch outputs are combinational from the registered flags and the current inputs. A branch presented in the same cycle as a compare therefore resolves against the flags that were set before that compare.

Top module: `ccbr_unit`

## Requirements
- R1: After a synchronous active-low reset all five flags are clear. A following equal branch (code 0) is not taken, and a not-equal branch (code 1) is taken.
- R2: On a compare strobe, every flag is first cleared. Then each flag that holds for the operand pair is set: equal, signed less, signed greater, unsigned less and unsigned greater. Equal excludes both orderings.
- R3: Without a compare strobe the flags keep their value, whatever the operand inputs carry.
- R4: The condition code is instruction bits 13:10. Codes 0 to 5 select: equal, not equal, signed less, signed greater, unsigned less, unsigned greater.
- R5: Codes 6 to 9 select signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal and unsigned less-or-equal. Each is taken when its ordering flag or the equal flag is set.
- R6: A taken branch gives a next PC equal to the input PC plus the displacement. The displacement is instruction bits 9:0, sign-extended and shifted left one bit, and the sum wraps modulo 2^ADDR_W.
- R7: A legal branch whose condition fails is not taken, and the next PC equals the input PC.
- R8: Codes 10 to 15 raise the illegal flag. They are never taken and leave the next PC equal to the input PC.
- R9: With the branch strobe low, taken and illegal are low and the next PC equals the input PC, whatever the instruction holds.
- R10: A branch and a compare in the same cycle resolve against the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_en | input | 1 | Compare strobe, loads the flags |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| br_valid | input | 1 | Branch instruction present |
| br_insn | input | INSN_W | Branch instruction word |
| pc_in | input | ADDR_W | PC already stepped past the branch |
| pc_next | output | ADDR_W | Resolved next PC |
| br_taken | output | 1 | Branch taken |
| br_illegal | output | 1 | Condition code not defined |

## Verification
The bench uses the default 32-bit data and address widths and a 10-bit displacement field. These widths bring the extreme displacements within reach: +1022 from field 0x1FF and -1024 from field 0x200. They also allow PC wraparound at both ends of the 32-bit space. Operands with the sign bit set are compared against small positive values, so the signed and unsigned flags disagree. Every one of the sixteen condition codes is then evaluated against those flags.

// File: rtl/ccbr_pkg.sv
// Shared types for the condition-code branch unit.
// Assumes a 4-bit condition code; ten codes are defined.
package ccbr_pkg;

    typedef struct packed {
        logic gtu;
        logic ltu;
        logic gt;
        logic lt;
        logic eq;
    } cc_flags_t;

    typedef enum logic [3:0] {
        C_EQ  = 4'd0,
        C_NE  = 4'd1,
        C_LT  = 4'd2,
        C_GT  = 4'd3,
        C_LTU = 4'd4,
        C_GTU = 4'd5,
        C_GE  = 4'd6,
        C_LE  = 4'd7,
        C_GEU = 4'd8,
        C_LEU = 4'd9
    } cond_e;

    localparam int unsigned NUM_CONDS = 10;
    localparam int unsigned CODE_W    = 4;

    // Evaluates one condition code against a flag set; undefined codes give 0.
    function automatic logic cond_holds(input logic [CODE_W-1:0] code, input cc_flags_t f);
        logic r;
        case (code)
            C_EQ:    r = f.eq;
            C_NE:    r = !f.eq;
            C_LT:    r = f.lt;
            C_GT:    r = f.gt;
            C_LTU:   r = f.ltu;
            C_GTU:   r = f.gtu;
            C_GE:    r = f.gt  | f.eq;
            C_LE:    r = f.lt  | f.eq;
            C_GEU:   r = f.gtu | f.eq;
            C_LEU:   r = f.ltu | f.eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccbr_flags.sv
// Condition flag register.
// Loads all five flags from a fresh compare of two operands when cmp_en is
// high, otherwise holds. Assumes synchronous active-low reset to all clear.
module ccbr_flags
    import ccbr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output cc_flags_t         flags_q
);

    cc_flags_t flags_d;

    // Builds the new flag set from scratch so no stale flag survives.
    always_comb begin
        flags_d     = '0;
        flags_d.eq  = (cmp_a == cmp_b);
        flags_d.lt  = ($signed(cmp_a) < $signed(cmp_b));
        flags_d.gt  = ($signed(cmp_a) > $signed(cmp_b));
        flags_d.ltu = (cmp_a < cmp_b);
        flags_d.gtu = (cmp_a > cmp_b);
    end

    // Flag storage: cleared on reset, loaded only on a compare strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (cmp_en) begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/ccbr_cond.sv
// Condition decoder.
// Evaluates every code against the flags in parallel and selects one.
// Assumes codes at or above NUM_CONDS are undefined.
module ccbr_cond
    import ccbr_pkg::*;
(
    input  cc_flags_t         flags,
    input  logic [CODE_W-1:0] code,
    output logic              cond_true,
    output logic              code_legal
);

    localparam int unsigned NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0] hit;

    // One evaluator per code value; undefined codes evaluate to 0.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign hit[i] = cond_holds(CODE_W'(i), flags);
    end

    // Selects the addressed condition and flags undefined codes.
    always_comb begin
        cond_true  = hit[code];
        code_legal = (32'(code) < NUM_CONDS);
    end

endmodule

// File: rtl/ccbr_target.sv
// Branch target adder.
// Sign-extends the displacement field, scales it to halfwords and adds it
// to the PC. Assumes the PC has already been stepped past the branch.
module ccbr_target #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [OFF_W-1:0]  off_field,
    output logic [ADDR_W-1:0] pc_taken
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;

    logic [ADDR_W-1:0] disp;

    // Forms the byte displacement and the wrapped target address.
    always_comb begin
        disp     = {{EXT_W{off_field[OFF_W-1]}}, off_field, 1'b0};
        pc_taken = pc_in + disp;
    end

endmodule

// File: rtl/ccbr_unit.sv
// Condition-code branch evaluation unit (top).
// Holds compare flags and resolves short-form conditional branches in the
// same cycle they are presented. Assumes pc_in already points past the
// 2-byte branch; a branch sees the flags registered before this cycle.
module ccbr_unit
    import ccbr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned INSN_W = 16,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned OP_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_valid,
    input  logic [INSN_W-1:0] br_insn,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc_next,
    output logic              br_taken,
    output logic              br_illegal
);

    localparam int unsigned OP_MSB = OP_LSB + CODE_W - 1;

    cc_flags_t         cc_q;
    logic [CODE_W-1:0] code;
    logic              cond_true;
    logic              code_legal;
    logic [ADDR_W-1:0] pc_taken;
    logic              unused_fmt;

    assign code       = br_insn[OP_MSB:OP_LSB];
    // Format bits above the code field are decoded elsewhere.
    assign unused_fmt = ^br_insn[INSN_W-1:OP_MSB+1];

    ccbr_flags #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_en  (cmp_en),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .flags_q (cc_q)
    );

    ccbr_cond u_cond (
        .flags      (cc_q),
        .code       (code),
        .cond_true  (cond_true),
        .code_legal (code_legal)
    );

    ccbr_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_target (
        .pc_in     (pc_in),
        .off_field (br_insn[OFF_W-1:0]),
        .pc_taken  (pc_taken)
    );

    // Resolves the branch outcome and the next PC.
    always_comb begin
        br_taken   = br_valid && code_legal && cond_true;
        br_illegal = br_valid && !code_legal;
        pc_next    = br_taken ? pc_taken : pc_in;
    end

endmodule

// File: rtl/ccbr_unit_chk.sv
// Property checker for ccbr_unit, attached by bind.
module ccbr_unit_chk
    import ccbr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_en,
    input logic [DATA_W-1:0] cmp_a,
    input logic [DATA_W-1:0] cmp_b,
    input logic              br_valid,
    input logic [ADDR_W-1:0] pc_in,
    input logic [ADDR_W-1:0] pc_next,
    input logic              br_taken,
    input logic              br_illegal,
    input cc_flags_t         flags
);

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(flags)); // R3

    AST_EQ_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> flags.eq == ($past(cmp_a) == $past(cmp_b))); // R2

    AST_SIGNED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.eq, flags.lt, flags.gt})); // R2

    AST_UNSIGNED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.eq, flags.ltu, flags.gtu})); // R2

    AST_NOT_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_taken) |-> pc_next == pc_in); // R7

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> (!br_taken && pc_next == pc_in)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> (!br_taken && !br_illegal && pc_next == pc_in)); // R9

endmodule

bind ccbr_unit ccbr_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (cmp_en),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .br_valid   (br_valid),
    .pc_in      (pc_in),
    .pc_next    (pc_next),
    .br_taken   (br_taken),
    .br_illegal (br_illegal),
    .flags      (cc_q)
);

// File: tb/ccbr_unit_bench.sv
module ccbr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_en;
    logic [31:0] cmp_a, cmp_b;
    logic        br_valid;
    logic [15:0] br_insn;
    logic [31:0] pc_in;
    logic [31:0] pc_next;
    logic        br_taken, br_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference flags, kept behaviourally.
    bit m_eq, m_lt, m_gt, m_ltu, m_gtu;

    always #4 clk = ~clk;

    ccbr_unit u_ccbr_unit (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_valid(br_valid), .br_insn(br_insn), .pc_in(pc_in),
        .pc_next(pc_next), .br_taken(br_taken), .br_illegal(br_illegal)
    );

    task automatic check_out(input string tag);
        int  op;
        int  d;
        bit  c;
        bit  e_t, e_i;
        logic [31:0] e_pc;
        op = int'(br_insn[13:10]);
        c  = 0;
        case (op)
            0: c = m_eq;
            1: c = !m_eq;
            2: c = m_lt;
            3: c = m_gt;
            4: c = m_ltu;
            5: c = m_gtu;
            6: c = m_gt || m_eq;
            7: c = m_lt || m_eq;
            8: c = m_gtu || m_eq;
            9: c = m_ltu || m_eq;
            default: c = 0;
        endcase
        d = int'(br_insn[9:0]);
        if (d >= 512) d = d - 1024;
        d = d * 2;
        e_i  = br_valid && (op > 9);
        e_t  = br_valid && (op <= 9) && c;
        e_pc = e_t ? pc_in + 32'(d) : pc_in;
        checks++;
        if (br_taken !== e_t || br_illegal !== e_i || pc_next !== e_pc) begin
            fails++;
            $display("FAIL %s: taken=%0b illegal=%0b pc=%h expected taken=%0b illegal=%0b pc=%h",
                     tag, br_taken, br_illegal, pc_next, e_t, e_i, e_pc);
        end
    endtask

    // One cycle: check at the falling edge, advance the model at the rising edge.
    task automatic step(input string tag);
        @(negedge clk);
        check_out(tag);
        @(posedge clk);
        if (!rst_n) begin
            {m_eq, m_lt, m_gt, m_ltu, m_gtu} = '0;
        end else if (cmp_en) begin
            m_eq  = (cmp_a == cmp_b);
            m_lt  = ($signed(cmp_a) < $signed(cmp_b));
            m_gt  = ($signed(cmp_a) > $signed(cmp_b));
            m_ltu = (cmp_a < cmp_b);
            m_gtu = (cmp_a > cmp_b);
        end
        #1;
    endtask

    task automatic set_br(input int op, input int off);
        br_valid = 1'b1;
        br_insn  = {2'b11, 4'(op), 10'(off)};
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        cmp_en = 1'b1; cmp_a = a; cmp_b = b; br_valid = 1'b0;
        step("R2");
        cmp_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: expired expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cmp_en = 1; cmp_a = 7; cmp_b = 7;
        br_valid = 0; br_insn = 16'hFFFF; pc_in = 32'h100;
        {m_eq, m_lt, m_gt, m_ltu, m_gtu} = '0;
        step("R9"); step("R9");
        rst_n = 1; cmp_en = 0;

        // R1: flags clear after reset
        set_br(0, 5); step("R1");
        set_br(1, 5); step("R1");

        // R2 / R4: signed and unsigned disagree
        do_cmp(32'hFFFF_FFFF, 32'd1);
        for (int op = 0; op < 10; op++) begin set_br(op, 3); step("R4"); end
        do_cmp(32'd1, 32'h8000_0000);
        for (int op = 0; op < 10; op++) begin set_br(op, 3); step("R4"); end

        // R5: or-equal conditions after equality
        do_cmp(32'h1234, 32'h1234);
        for (int op = 0; op < 10; op++) begin set_br(op, 7); step("R5"); end

        // R3: operands move without the strobe
        cmp_a = 1; cmp_b = 2;
        set_br(0, 1); step("R3");
        set_br(2, 1); step("R3");

        // R6: displacement extremes and wrap
        pc_in = 32'h0000_0002; set_br(0, 10'h200); step("R6");
        pc_in = 32'hFFFF_FFFE; set_br(0, 10'h1FF); step("R6");
        pc_in = 32'h0000_4000; set_br(0, 10'h3FF); step("R6");
        set_br(0, 10'h000); step("R6");

        // R7: failing condition
        set_br(1, 10'h155); step("R7");

        // R8: undefined codes
        for (int op = 10; op < 16; op++) begin set_br(op, 9); step("R8"); end

        // R9: strobe low
        br_valid = 0; br_insn = {2'b11, 4'd1, 10'h3F}; step("R9");

        // R10: compare and branch together see the old (equal) flags
        cmp_en = 1; cmp_a = 3; cmp_b = 9; set_br(0, 4); step("R10");
        cmp_en = 0; set_br(0, 4); step("R2");

        // Random mix against the model
        for (int n = 0; n < 3000; n++) begin
            cmp_en   = ($urandom_range(0, 2) == 0);
            cmp_a    = ($urandom_range(0, 3) == 0) ? cmp_b : $urandom;
            cmp_b    = $urandom;
            br_valid = ($urandom_range(0, 3) != 0);
            br_insn  = 16'($urandom);
            pc_in    = $urandom;
            step("R6");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule